// File: doc/BRIEF.md
# UART Channel Mode Data Router

This block sits between the byte side of a UART receiver, the byte side of its transmitter and the host's data register. A 2-bit channel mode decides where each byte goes. Bytes may come from the line, from a host write, or be a zero byte made from a detected line break. Each byte can be stored in the receive queue, sent back out through the transmit queue, or thrown away. Both queues live inside the block. Each is a first-in first-out store, 8 bits wide and 16 entries deep by default, with a show-ahead head, empty and full flags, and a sticky overflow flag.

The receive queue accepts one byte per cycle. When two sources want it in the same cycle, the loser waits in a one-entry holding register and is written on the next cycle. The transmit queue never has more than one source in any mode, so it needs no arbitration. The serial side of the UART (bit timing, baud rate, parity, framing) is outside this block. The router sees only whole bytes and break strobes.

Top module: `uart_chan_router`

## Requirements
- R1: `mode_sel` encodes 2'b00 normal, 2'b01 automatic echo, 2'b10 local loopback, 2'b11 remote loopback. In normal mode a line byte goes to the receive queue and a host write goes to the transmit queue.
- R2: In automatic echo mode (2'b01) a line byte is written to both the receive queue and the transmit queue.
- R3: In remote loopback mode (2'b11) a line byte goes to the transmit queue only and never enters the receive queue.
- R4: In local loopback mode (2'b10) a host write goes to the receive queue and not the transmit queue, and line bytes are discarded.
- R5: In echo (2'b01) and remote loopback (2'b11) modes, host writes reach neither queue.
- R6: A break strobe writes one byte of value 0x00 into the receive queue in every mode.
- R7: When several new bytes target the receive queue in one cycle, the priority is break, then line byte, then host byte. The winner is written that cycle and the next one in priority is written on the following cycle.
- R8: A held byte is written before any new byte. Of the new bytes that lose in that cycle, the first in priority is held and any other is dropped, which sets the receive overflow flag.
- R9: Each queue returns bytes in the order written. The head byte is shown on the data output while the empty flag is low, full is high at 16 entries, and a pop on an empty queue has no effect.
- R10: A push into a full queue is dropped, the stored bytes are kept, and that queue's overflow flag sets and stays set until `ovf_clr` is pulsed.
- R11: After reset both queues are empty, both overflow flags are low and the holding register is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Channel mode (00 normal, 01 echo, 10 local loop, 11 remote loop) |
| line_vld | input | 1 | A received byte is present this cycle |
| line_byte | input | 8 | Received byte |
| brk_seen | input | 1 | Line break detected this cycle |
| host_wr | input | 1 | Host write to the data register |
| host_byte | input | 8 | Host write data |
| rxq_pop | input | 1 | Remove the head of the receive queue |
| txq_pop | input | 1 | Remove the head of the transmit queue |
| ovf_clr | input | 1 | Clear both overflow flags |
| rxq_head | output | 8 | Receive queue head byte |
| rxq_empty | output | 1 | Receive queue empty |
| rxq_full | output | 1 | Receive queue full |
| rxq_ovf | output | 1 | Receive queue overflow, sticky |
| txq_head | output | 8 | Transmit queue head byte |
| txq_empty | output | 1 | Transmit queue empty |
| txq_full | output | 1 | Transmit queue full |
| txq_ovf | output | 1 | Transmit queue overflow, sticky |

## Verification
The assertions check the following on every cycle: a break is written with the zero byte unless a held byte goes first, a held byte always drains on the next cycle, remote loopback never feeds the receive queue from the line, and echo and remote modes never pass a host byte to the transmit queue. They also check that a full queue keeps its count when pushed and that the overflow flag stays set until cleared. Only the bench scenarios can show the full routing of each mode end to end, the order of bytes after a conflict, the dropped third competitor, and first-in first-out order across a full queue. These depend on what is later read out of the queues.

// File: rtl/uart_route_pkg.sv
package uart_route_pkg;
   typedef enum logic [1:0] {
      CH_NORMAL = 2'b00,
      CH_ECHO   = 2'b01,
      CH_LOCAL  = 2'b10,
      CH_REMOTE = 2'b11
   } chan_mode_e;
endpackage

// File: rtl/route_fifo.sv
module route_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] din_i,
   input  logic         pop_i,
   input  logic         lose_i,
   input  logic         clr_i,
   output logic [W-1:0] head_o,
   output logic         empty_o,
   output logic         full_o,
   output logic         ovf_o
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("route_fifo: DEPTH must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("route_fifo: W must be at least 1");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] count;
   logic          ovf_q, do_push, do_pop;

   assign full_o  = (count == CNT_MAX);
   assign empty_o = (count == '0);
   assign do_push = push_i && !full_o;
   assign do_pop  = pop_i && !empty_o;

   // pointer wrap: free wrap for power-of-two depths, compare otherwise
   generate
      if ((1 << AW) == DEPTH) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         ovf_q  <= 1'b0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         if (clr_i)
            ovf_q <= 1'b0;
         else if ((push_i && full_o) || lose_i)
            ovf_q <= 1'b1;
      end
   end

   assign head_o = mem[rd_ptr];
   assign ovf_o  = ovf_q;

   a_r10_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && push_i && !pop_i) |=> full_o);
   a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !clr_i) |=> ovf_q);
   a_r9_pop_empty_noop: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_o && pop_i && !push_i) |=> empty_o);
   a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_MAX);
endmodule

// File: rtl/route_arb.sv
module route_arb
   import uart_route_pkg::*;
#(
   parameter int           W   = 8,
   parameter logic [W-1:0] BRK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  chan_mode_e   mode,
   input  logic         line_vld,
   input  logic [W-1:0] line_byte,
   input  logic         brk_seen,
   input  logic         host_wr,
   input  logic [W-1:0] host_byte,
   output logic         rx_push,
   output logic [W-1:0] rx_data,
   output logic         rx_lose,
   output logic         tx_push,
   output logic [W-1:0] tx_data
);
   localparam int NSRC = 4;   // held, break, line, host in priority order

   logic         hold_v, hold_v_n;
   logic [W-1:0] hold_d, hold_d_n;
   logic         line_to_rx, host_to_rx, line_to_tx, host_to_tx;
   logic [NSRC-1:0] req;
   logic [W-1:0]    cand [NSRC];
   logic [1:0]      taken;

   assign line_to_rx = line_vld && (mode == CH_NORMAL || mode == CH_ECHO);
   assign line_to_tx = line_vld && (mode == CH_ECHO || mode == CH_REMOTE);
   assign host_to_rx = host_wr && (mode == CH_LOCAL);
   assign host_to_tx = host_wr && (mode == CH_NORMAL);

   assign req     = {host_to_rx, line_to_rx, brk_seen, hold_v};
   assign cand[0] = hold_d;
   assign cand[1] = BRK;
   assign cand[2] = line_byte;
   assign cand[3] = host_byte;

   always_comb begin
      rx_push  = 1'b0;
      rx_data  = '0;
      hold_v_n = 1'b0;
      hold_d_n = hold_d;
      rx_lose  = 1'b0;
      taken    = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (req[i]) begin
            if (taken == 2'd0) begin
               rx_push = 1'b1;
               rx_data = cand[i];
            end else if (taken == 2'd1) begin
               hold_v_n = 1'b1;
               hold_d_n = cand[i];
            end else begin
               rx_lose = 1'b1;
            end
            if (taken != 2'd3) taken = taken + 1'b1;
         end
      end
   end

   assign tx_push = line_to_tx || host_to_tx;
   assign tx_data = host_to_tx ? host_byte : line_byte;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_v <= 1'b0;
         hold_d <= '0;
      end else begin
         hold_v <= hold_v_n;
         hold_d <= hold_d_n;
      end
   end

   a_r6_break_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_seen && !hold_v) |-> (rx_push && rx_data == BRK));
   a_r8_hold_drains: assert property (@(posedge clk) disable iff (!rst_n)
      hold_v |-> rx_push);
   a_r3_remote_no_line_rx: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == CH_REMOTE && !hold_v && !brk_seen) |-> !rx_push);
   a_r5_host_discard: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == CH_ECHO || mode == CH_REMOTE) && !line_vld) |-> !tx_push);
endmodule

// File: rtl/uart_chan_router.sv
module uart_chan_router
   import uart_route_pkg::*;
#(
   parameter int                DATA_W     = 8,
   parameter int                FIFO_DEPTH = 16,
   parameter logic [DATA_W-1:0] BRK_BYTE   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_sel,
   input  logic              line_vld,
   input  logic [DATA_W-1:0] line_byte,
   input  logic              brk_seen,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_byte,
   input  logic              rxq_pop,
   input  logic              txq_pop,
   input  logic              ovf_clr,
   output logic [DATA_W-1:0] rxq_head,
   output logic              rxq_empty,
   output logic              rxq_full,
   output logic              rxq_ovf,
   output logic [DATA_W-1:0] txq_head,
   output logic              txq_empty,
   output logic              txq_full,
   output logic              txq_ovf
);
   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("uart_chan_router: DATA_W must be positive");
      end
   endgenerate

   chan_mode_e        mode;
   logic              rx_push, rx_lose, tx_push;
   logic [DATA_W-1:0] rx_data, tx_data;

   assign mode = chan_mode_e'(mode_sel);

   route_arb #(.W(DATA_W), .BRK(BRK_BYTE)) u_arb (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .line_vld(line_vld), .line_byte(line_byte), .brk_seen(brk_seen),
      .host_wr(host_wr), .host_byte(host_byte),
      .rx_push(rx_push), .rx_data(rx_data), .rx_lose(rx_lose),
      .tx_push(tx_push), .tx_data(tx_data)
   );

   route_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push_i(rx_push), .din_i(rx_data),
      .pop_i(rxq_pop), .lose_i(rx_lose), .clr_i(ovf_clr),
      .head_o(rxq_head), .empty_o(rxq_empty), .full_o(rxq_full), .ovf_o(rxq_ovf)
   );

   route_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push_i(tx_push), .din_i(tx_data),
      .pop_i(txq_pop), .lose_i(1'b0), .clr_i(ovf_clr),
      .head_o(txq_head), .empty_o(txq_empty), .full_o(txq_full), .ovf_o(txq_ovf)
   );
endmodule

// File: tb/uart_chan_router_tb_top.sv
module uart_chan_router_tb_top;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_sel = 2'b00;
   logic       line_vld = 1'b0, brk_seen = 1'b0, host_wr = 1'b0;
   logic [7:0] line_byte = '0, host_byte = '0;
   logic       rxq_pop = 1'b0, txq_pop = 1'b0, ovf_clr = 1'b0;
   logic [7:0] rxq_head, txq_head;
   logic       rxq_empty, rxq_full, rxq_ovf, txq_empty, txq_full, txq_ovf;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   uart_chan_router dut_i (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
      .line_vld(line_vld), .line_byte(line_byte), .brk_seen(brk_seen),
      .host_wr(host_wr), .host_byte(host_byte),
      .rxq_pop(rxq_pop), .txq_pop(txq_pop), .ovf_clr(ovf_clr),
      .rxq_head(rxq_head), .rxq_empty(rxq_empty), .rxq_full(rxq_full), .rxq_ovf(rxq_ovf),
      .txq_head(txq_head), .txq_empty(txq_empty), .txq_full(txq_full), .txq_ovf(txq_ovf)
   );

   typedef struct packed {
      logic [1:0] mode;
      logic       lv;
      logic [7:0] lb;
      logic       brk;
      logic       hw;
      logic [7:0] hb;
      logic [1:0] nrx;
      logic [7:0] rx0;
      logic [7:0] rx1;
      logic [1:0] ntx;
      logic [7:0] tx0;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      '{2'b00, 1'b1, 8'h41, 1'b0, 1'b0, 8'h00, 2'd1, 8'h41, 8'h00, 2'd0, 8'h00}, // R1
      '{2'b00, 1'b0, 8'h00, 1'b0, 1'b1, 8'h52, 2'd0, 8'h00, 8'h00, 2'd1, 8'h52}, // R1
      '{2'b00, 1'b1, 8'h11, 1'b0, 1'b1, 8'h22, 2'd1, 8'h11, 8'h00, 2'd1, 8'h22}, // R1
      '{2'b01, 1'b1, 8'h33, 1'b0, 1'b1, 8'h44, 2'd1, 8'h33, 8'h00, 2'd1, 8'h33}, // R2 R5
      '{2'b10, 1'b1, 8'h66, 1'b0, 1'b1, 8'h55, 2'd1, 8'h55, 8'h00, 2'd0, 8'h00}, // R4
      '{2'b11, 1'b1, 8'h77, 1'b0, 1'b1, 8'h88, 2'd0, 8'h00, 8'h00, 2'd1, 8'h77}, // R3 R5
      '{2'b00, 1'b1, 8'h99, 1'b1, 1'b0, 8'h00, 2'd2, 8'h00, 8'h99, 2'd0, 8'h00}, // R6 R7
      '{2'b10, 1'b0, 8'h00, 1'b1, 1'b1, 8'hAB, 2'd2, 8'h00, 8'hAB, 2'd0, 8'h00}, // R6 R7
      '{2'b11, 1'b1, 8'hCD, 1'b1, 1'b0, 8'h00, 2'd1, 8'h00, 8'h00, 2'd1, 8'hCD}, // R3 R6
      '{2'b01, 1'b1, 8'hEE, 1'b1, 1'b0, 8'h00, 2'd2, 8'h00, 8'hEE, 2'd1, 8'hEE}  // R2 R7
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pop_rx(input string req, input logic [7:0] exp);
      chk(req, {31'd0, rxq_empty}, 32'd0);
      chk(req, {24'd0, rxq_head}, {24'd0, exp});
      rxq_pop = 1'b1;
      @(negedge clk);
      rxq_pop = 1'b0;
   endtask

   task automatic pop_tx(input string req, input logic [7:0] exp);
      chk(req, {31'd0, txq_empty}, 32'd0);
      chk(req, {24'd0, txq_head}, {24'd0, exp});
      txq_pop = 1'b1;
      @(negedge clk);
      txq_pop = 1'b0;
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 rx empty", {31'd0, rxq_empty}, 32'd1);
      chk("R11 tx empty", {31'd0, txq_empty}, 32'd1);
      chk("R11 rx ovf", {31'd0, rxq_ovf}, 32'd0);
      chk("R11 tx ovf", {31'd0, txq_ovf}, 32'd0);

      // vector table: R1..R7 routing per mode
      foreach (VEC[k]) begin
         mode_sel = VEC[k].mode;
         line_vld = VEC[k].lv;  line_byte = VEC[k].lb;
         brk_seen = VEC[k].brk;
         host_wr  = VEC[k].hw;  host_byte = VEC[k].hb;
         @(negedge clk);
         line_vld = 1'b0; brk_seen = 1'b0; host_wr = 1'b0;
         idle(2);
         if (VEC[k].nrx > 0) pop_rx($sformatf("R1-route vec%0d rx0", k), VEC[k].rx0);
         if (VEC[k].nrx > 1) pop_rx($sformatf("R7 vec%0d rx1", k), VEC[k].rx1);
         chk($sformatf("R3 R4 vec%0d rx count", k), {31'd0, rxq_empty}, 32'd1);
         if (VEC[k].ntx > 0) pop_tx($sformatf("R2 vec%0d tx0", k), VEC[k].tx0);
         chk($sformatf("R5 vec%0d tx count", k), {31'd0, txq_empty}, 32'd1);
      end

      // R9 pop on empty has no effect
      mode_sel = 2'b10;
      rxq_pop = 1'b1;
      @(negedge clk);
      rxq_pop = 1'b0;
      host_wr = 1'b1; host_byte = 8'h5A;
      @(negedge clk);
      host_wr = 1'b0;
      pop_rx("R9 after empty pop", 8'h5A);
      chk("R9 empty after one", {31'd0, rxq_empty}, 32'd1);

      // R10 fill RX queue through local loopback, then overflow
      for (int i = 0; i < 16; i++) begin
         host_wr = 1'b1; host_byte = 8'(i + 8'h20);
         @(negedge clk);
      end
      host_wr = 1'b0;
      chk("R9 full at 16", {31'd0, rxq_full}, 32'd1);
      chk("R10 no ovf yet", {31'd0, rxq_ovf}, 32'd0);
      host_wr = 1'b1; host_byte = 8'hF0;
      @(negedge clk);
      host_wr = 1'b0;
      chk("R10 ovf set", {31'd0, rxq_ovf}, 32'd1);
      chk("R10 tx ovf untouched", {31'd0, txq_ovf}, 32'd0);
      for (int i = 0; i < 16; i++) pop_rx("R9 R10 order", 8'(i + 8'h20));
      chk("R10 dropped byte absent", {31'd0, rxq_empty}, 32'd1);
      chk("R10 ovf sticky", {31'd0, rxq_ovf}, 32'd1);
      ovf_clr = 1'b1;
      @(negedge clk);
      ovf_clr = 1'b0;
      chk("R10 ovf cleared", {31'd0, rxq_ovf}, 32'd0);

      // R8 held byte first, third competitor dropped
      mode_sel = 2'b10;
      brk_seen = 1'b1; host_wr = 1'b1; host_byte = 8'h61;
      @(negedge clk);
      host_byte = 8'h62;
      @(negedge clk);
      brk_seen = 1'b0; host_wr = 1'b0;
      idle(2);
      pop_rx("R8 first", 8'h00);
      pop_rx("R8 held host", 8'h61);
      pop_rx("R8 held break", 8'h00);
      chk("R8 third dropped", {31'd0, rxq_empty}, 32'd1);
      chk("R8 drop sets ovf", {31'd0, rxq_ovf}, 32'd1);

      // R11 reset clears queues and flags
      mode_sel = 2'b00;
      line_vld = 1'b1; line_byte = 8'h3C; host_wr = 1'b1; host_byte = 8'h4D;
      @(negedge clk);
      line_vld = 1'b0; host_wr = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 rx empty after reset", {31'd0, rxq_empty}, 32'd1);
      chk("R11 tx empty after reset", {31'd0, txq_empty}, 32'd1);
      chk("R11 ovf low after reset", {31'd0, rxq_ovf}, 32'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule